// File: doc/BRIEF.md
# Parallel Port Mode Negotiation Controller

This block is the host side of the handshake that moves a parallel port out of compatibility mode into either the nibble reverse mode or the extended-capability (ECP) mode, and that later hands the port back to compatibility mode. A single start pulse launches a negotiation. A single terminate pulse launches a termination. While the block is busy it owns the eight data lines and the four host control lines (strobe, auto-feed, init and select-in, all active low). It watches the five peripheral status lines (acknowledge, busy, paper-error, select and fault), and each of them passes through a two-flop synchronizer before any comparison is made.

Every wait is counted in ticks from a free-running clock prescaler. The setup interval and the response timeout are parameters, and the block reuses one tick counter that restarts on each state change. Each operation ends with a one-cycle `done_o` pulse. A 2-bit result code arrives with that pulse and stays on `status_o` until the next operation. `mode_o` always shows the mode the port is in at that moment.

States:
- `ST_IDLE`: waits for a request.
- `ST_NEG_SETUP`: the mode code is on the data lines for the setup interval.
- `ST_NEG_REQ`: the request is posted and the block waits for the peripheral's answer.
- `ST_NEG_STROBE`: strobe is held low for one tick.
- `ST_NEG_LATCH`: the block waits for acknowledge to rise.
- `ST_TRM_REQ`: the termination request is posted.
- `ST_TRM_HSK`: auto-feed is held low while the block waits for acknowledge to rise.

Transitions:
- start/refuse: `ST_IDLE` to `ST_IDLE`, with an I/O error.
- start: `ST_IDLE` to `ST_NEG_SETUP`.
- terminate: `ST_IDLE` to `ST_TRM_REQ`.
- setup done: to `ST_NEG_REQ`.
- answered: to `ST_NEG_STROBE`. No answer: to `ST_IDLE`, with a timeout.
- strobe done: to `ST_NEG_LATCH`.
- latched: to `ST_IDLE`, with ok or unsupported. Not latched: to `ST_IDLE`, with an I/O error.
- acknowledged: `ST_TRM_REQ` to `ST_TRM_HSK`. Not acknowledged: to `ST_IDLE`, with an I/O error.
- finished: to `ST_IDLE`, with ok. Not finished: to `ST_IDLE`, with an I/O error.

Top module: `p1284_negotiator`

## Requirements
- R1: A start in `ST_IDLE` while `n_selectin_o` is already high is refused. `done_o` rises on the next cycle with status I/O error (2'b10), and the mode and the control lines do not change.
- R2: An accepted start drives the mode code on `data_o` (0x00 for nibble when `mode_ecp_i`=0, 0x30 for ECP when `mode_ecp_i`=1) and holds it unchanged until the operation ends. `n_selectin_o` stays low for the setup interval.
- R3: After setup the block drives select-in high, auto-feed low, and strobe and init high. If PError, Select and nFault are not all high with nAck low within T_RESP ticks, the result is timeout (2'b01).
- R4: After the answer, strobe goes low for one tick, and only while auto-feed is low and select-in is high. Then all four control lines go high. If nAck does not rise within T_SETUP+T_RESP ticks, the result is I/O error.
- R5: A nibble request succeeds whatever Select shows. An ECP request succeeds only if Select is high when nAck rises; otherwise the result is unsupported (2'b11).
- R6: A successful negotiation sets `mode_o` to the requested mode (2'b01 nibble, 2'b10 ECP) and leaves all four control lines high. A failed negotiation leaves `mode_o` at compatibility (2'b00) and returns the lines to compatibility idle: select-in low, and the others high.
- R7: Termination drives select-in low and auto-feed, strobe and init high. `mode_o` reads compatibility from the first cycle of termination. If Busy and nFault are not both high with nAck low within T_SETUP+T_RESP ticks, the result is I/O error.
- R8: After that answer, auto-feed goes low until nAck rises. A rise within T_RESP ticks gives ok (2'b00); no rise gives I/O error. Either way auto-feed ends high.
- R9: Start and terminate are acted on only in `ST_IDLE`; while an operation runs they change nothing. When both arrive together, start wins.
- R10: `done_o` is a single-cycle pulse, one for each operation, raised only when the block is back in `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin negotiation (pulse) |
| term_i | input | 1 | Begin termination (pulse) |
| mode_ecp_i | input | 1 | Requested mode at start: 0 nibble, 1 ECP |
| data_o | output | 8 | Data lines toward the peripheral |
| n_strobe_o | output | 1 | Strobe, active low |
| n_autofd_o | output | 1 | Auto-feed, active low |
| n_init_o | output | 1 | Init, active low |
| n_selectin_o | output | 1 | Select-in, active low |
| n_ack_i | input | 1 | Acknowledge from peripheral, active low |
| busy_i | input | 1 | Busy from peripheral |
| perror_i | input | 1 | Paper-error from peripheral |
| select_i | input | 1 | Select from peripheral |
| n_fault_i | input | 1 | Fault from peripheral, active low |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| status_o | output | 2 | Result: 00 ok, 01 timeout, 10 I/O error, 11 unsupported |
| mode_o | output | 2 | Current mode: 00 compatibility, 01 nibble, 10 ECP |

## Verification
The control lines are decoded straight from the state register, so a state entered wrongly or skipped shows on the pins in the same cycle. Examples are a strobe pulse without auto-feed low, or select-in dropping while a 1284 mode is still reported. A wrong mode or tick count in the state machine shows up no later than the `done_o` pulse that closes the operation, as a wrong status code or a wrong `mode_o`. That pulse comes at most T_SETUP+T_RESP ticks after the last state change. The refusal path is visible one cycle after the start pulse.

// File: rtl/p1284_pkg.sv
package p1284_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_NEG_SETUP  = 3'd1,
        ST_NEG_REQ    = 3'd2,
        ST_NEG_STROBE = 3'd3,
        ST_NEG_LATCH  = 3'd4,
        ST_TRM_REQ    = 3'd5,
        ST_TRM_HSK    = 3'd6
    } fsm_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'b00,
        RES_TIMEOUT = 2'b01,
        RES_IOERR   = 2'b10,
        RES_UNSUP   = 2'b11
    } res_e;

    typedef enum logic [1:0] {
        MODE_COMPAT = 2'b00,
        MODE_NIBBLE = 2'b01,
        MODE_ECP    = 2'b10
    } pmode_e;

endpackage

// File: rtl/p1284_sync.sv
module p1284_sync #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= raw_i[i];
                stab_q <= meta_q;
            end
        end
        assign sync_o[i] = stab_q;
    end
endmodule

// File: rtl/p1284_tick.sv
module p1284_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/p1284_wait.sv
module p1284_wait #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         tick_i,
    input  logic [W-1:0] limit_i,
    output logic         expire_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (tick_i) cnt_q <= cnt_q + 1'b1;
    end

    assign expire_o = tick_i && (cnt_q == limit_i - 1'b1);
endmodule

// File: rtl/p1284_negotiator.sv
module p1284_negotiator
    import p1284_pkg::*;
#(
    parameter int         CLK_DIV     = 4,
    parameter int         T_SETUP     = 1,
    parameter int         T_RESP      = 6,
    parameter logic [7:0] NIBBLE_CODE = 8'h00,
    parameter logic [7:0] ECP_CODE    = 8'h30
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       term_i,
    input  logic       mode_ecp_i,
    output logic [7:0] data_o,
    output logic       n_strobe_o,
    output logic       n_autofd_o,
    output logic       n_init_o,
    output logic       n_selectin_o,
    input  logic       n_ack_i,
    input  logic       busy_i,
    input  logic       perror_i,
    input  logic       select_i,
    input  logic       n_fault_i,
    output logic       done_o,
    output logic [1:0] status_o,
    output logic [1:0] mode_o
);
    localparam int TW = $clog2(T_SETUP + T_RESP + 1);
    localparam int NSTAT = 5;

    fsm_e   state_q, state_d;
    pmode_e mode_q, mode_d;
    res_e   status_q, stat_d;
    logic   done_q, fire;
    logic   req_ecp_q;
    logic [7:0] data_q;

    logic [NSTAT-1:0] stat_s;
    logic ack_s, busy_s, pe_s, sel_s, flt_s;
    logic tick, expire, wclr;
    logic [TW-1:0] limit;

    p1284_sync #(.WIDTH(NSTAT)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({n_ack_i, busy_i, perror_i, select_i, n_fault_i}),
        .sync_o (stat_s)
    );
    assign {ack_s, busy_s, pe_s, sel_s, flt_s} = stat_s;

    p1284_tick #(.DIV(CLK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    p1284_wait #(.W(TW)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (wclr),
        .tick_i   (tick),
        .limit_i  (limit),
        .expire_o (expire)
    );

    assign wclr = (state_d != state_q) || (state_q == ST_IDLE);

    // Wait limit in ticks for the current state
    always_comb begin
        unique case (state_q)
            ST_NEG_SETUP:  limit = TW'(T_SETUP);
            ST_NEG_REQ:    limit = TW'(T_RESP);
            ST_NEG_STROBE: limit = TW'(1);
            ST_NEG_LATCH:  limit = TW'(T_SETUP + T_RESP);
            ST_TRM_REQ:    limit = TW'(T_SETUP + T_RESP);
            ST_TRM_HSK:    limit = TW'(T_RESP);
            default:       limit = TW'(1);
        endcase
    end

    // Next state, mode and result
    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        stat_d  = status_q;
        fire    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (n_selectin_o) begin
                        fire   = 1'b1;
                        stat_d = RES_IOERR;
                    end else begin
                        state_d = ST_NEG_SETUP;
                    end
                end else if (term_i) begin
                    state_d = ST_TRM_REQ;
                    mode_d  = MODE_COMPAT;
                end
            end
            ST_NEG_SETUP: begin
                if (expire) state_d = ST_NEG_REQ;
            end
            ST_NEG_REQ: begin
                if (pe_s && sel_s && flt_s && !ack_s) begin
                    state_d = ST_NEG_STROBE;
                end else if (expire) begin
                    state_d = ST_IDLE;
                    fire    = 1'b1;
                    stat_d  = RES_TIMEOUT;
                end
            end
            ST_NEG_STROBE: begin
                if (expire) state_d = ST_NEG_LATCH;
            end
            ST_NEG_LATCH: begin
                if (ack_s) begin
                    state_d = ST_IDLE;
                    fire    = 1'b1;
                    if (!req_ecp_q || sel_s) begin
                        stat_d = RES_OK;
                        mode_d = req_ecp_q ? MODE_ECP : MODE_NIBBLE;
                    end else begin
                        stat_d = RES_UNSUP;
                    end
                end else if (expire) begin
                    state_d = ST_IDLE;
                    fire    = 1'b1;
                    stat_d  = RES_IOERR;
                end
            end
            ST_TRM_REQ: begin
                if (busy_s && flt_s && !ack_s) begin
                    state_d = ST_TRM_HSK;
                end else if (expire) begin
                    state_d = ST_IDLE;
                    fire    = 1'b1;
                    stat_d  = RES_IOERR;
                end
            end
            ST_TRM_HSK: begin
                if (ack_s) begin
                    state_d = ST_IDLE;
                    fire    = 1'b1;
                    stat_d  = RES_OK;
                end else if (expire) begin
                    state_d = ST_IDLE;
                    fire    = 1'b1;
                    stat_d  = RES_IOERR;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            mode_q    <= MODE_COMPAT;
            status_q  <= RES_OK;
            done_q    <= 1'b0;
            req_ecp_q <= 1'b0;
            data_q    <= '0;
        end else begin
            state_q  <= state_d;
            mode_q   <= mode_d;
            done_q   <= fire;
            if (fire) status_q <= stat_d;
            if (state_q == ST_IDLE && state_d == ST_NEG_SETUP) begin
                req_ecp_q <= mode_ecp_i;
                data_q    <= mode_ecp_i ? ECP_CODE : NIBBLE_CODE;
            end
        end
    end

    // Control lines decoded from state
    always_comb begin
        n_strobe_o   = 1'b1;
        n_autofd_o   = 1'b1;
        n_init_o     = 1'b1;
        n_selectin_o = 1'b0;
        unique case (state_q)
            ST_IDLE:       n_selectin_o = (mode_q != MODE_COMPAT);
            ST_NEG_SETUP:  n_selectin_o = 1'b0;
            ST_NEG_REQ: begin
                n_selectin_o = 1'b1;
                n_autofd_o   = 1'b0;
            end
            ST_NEG_STROBE: begin
                n_selectin_o = 1'b1;
                n_autofd_o   = 1'b0;
                n_strobe_o   = 1'b0;
            end
            ST_NEG_LATCH:  n_selectin_o = 1'b1;
            ST_TRM_REQ:    n_selectin_o = 1'b0;
            ST_TRM_HSK:    n_autofd_o   = 1'b0;
            default:       n_selectin_o = 1'b0;
        endcase
    end

    assign data_o   = data_q;
    assign done_o   = done_q;
    assign status_o = status_q;
    assign mode_o   = mode_q;
endmodule

// File: rtl/p1284_negotiator_chk.sv
module p1284_negotiator_chk
    import p1284_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input fsm_e       state,
    input logic [7:0] data_o,
    input logic       n_strobe_o,
    input logic       n_autofd_o,
    input logic       n_selectin_o,
    input logic       done_o,
    input logic [1:0] status_o,
    input logic [1:0] mode_o
);
    AST_REFUSE_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start_i && n_selectin_o) |=> (done_o && status_o == RES_IOERR)); // R1

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(data_o)); // R2

    AST_STROBE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !n_strobe_o |-> (n_selectin_o && !n_autofd_o)); // R4

    AST_COMPAT_WHEN_SELIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !n_selectin_o |-> (mode_o == MODE_COMPAT)); // R7

    AST_MODE_HELD_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) == ST_IDLE) |-> $stable(mode_o)); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10

    AST_DONE_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (state == ST_IDLE)); // R10
endmodule

bind p1284_negotiator p1284_negotiator_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .state        (state_q),
    .data_o       (data_o),
    .n_strobe_o   (n_strobe_o),
    .n_autofd_o   (n_autofd_o),
    .n_selectin_o (n_selectin_o),
    .done_o       (done_o),
    .status_o     (status_o),
    .mode_o       (mode_o)
);

// File: tb/tb_p1284_negotiator.sv
module tb_p1284_negotiator;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, term_i = 1'b0, mode_ecp_i = 1'b0;
    logic [7:0] data_o;
    logic n_strobe_o, n_autofd_o, n_init_o, n_selectin_o;
    logic n_ack_i, busy_i, perror_i, select_i, n_fault_i;
    logic done_o;
    logic [1:0] status_o, mode_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [3:0] exp_q[$];

    // peripheral model controls
    bit p_resp, p_ack6, p_sel, p_tresp, p_ack27, m_clr;
    bit stb_seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    p1284_negotiator dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .term_i(term_i),
        .mode_ecp_i(mode_ecp_i), .data_o(data_o), .n_strobe_o(n_strobe_o),
        .n_autofd_o(n_autofd_o), .n_init_o(n_init_o), .n_selectin_o(n_selectin_o),
        .n_ack_i(n_ack_i), .busy_i(busy_i), .perror_i(perror_i),
        .select_i(select_i), .n_fault_i(n_fault_i), .done_o(done_o),
        .status_o(status_o), .mode_o(mode_o)
    );

    // Behavioural peripheral reacting to the control lines
    always_ff @(posedge clk) begin
        if (m_clr) begin
            n_ack_i <= 1'b1; busy_i <= 1'b0; perror_i <= 1'b0;
            select_i <= 1'b0; n_fault_i <= 1'b1;
        end else if (n_selectin_o && !n_autofd_o && n_strobe_o) begin
            if (p_resp) begin
                n_ack_i <= 1'b0; perror_i <= 1'b1; select_i <= 1'b1; n_fault_i <= 1'b1;
            end
        end else if (n_selectin_o && n_autofd_o && n_strobe_o) begin
            if (p_ack6) begin
                n_ack_i <= 1'b1; select_i <= p_sel;
            end
        end else if (!n_selectin_o && n_autofd_o) begin
            if (p_tresp) begin
                busy_i <= 1'b1; n_fault_i <= 1'b1; n_ack_i <= 1'b0;
            end
        end else if (!n_selectin_o && !n_autofd_o) begin
            if (p_ack27) n_ack_i <= 1'b1;
        end
    end

    always @(negedge clk) if (!n_strobe_o) stb_seen = 1'b1;

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10", "unexpected done", 1, 0);
            end else begin
                logic [3:0] e;
                e = exp_q.pop_front();
                check(status_o == e[3:2], "R10", "status", status_o, e[3:2]);
                check(mode_o == e[1:0], "R6", "mode", mode_o, e[1:0]);
            end
        end
    end

    task automatic set_model(bit resp, bit ack6, bit sel, bit tresp, bit ack27);
        p_resp = resp; p_ack6 = ack6; p_sel = sel; p_tresp = tresp; p_ack27 = ack27;
        @(negedge clk); m_clr = 1'b1;
        @(negedge clk); m_clr = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_done();
        while (!done_o) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic launch(bit neg, bit ecp, logic [1:0] es, logic [1:0] em);
        exp_q.push_back({es, em});
        stb_seen = 1'b0;
        @(negedge clk);
        start_i = neg; term_i = !neg; mode_ecp_i = ecp;
        @(negedge clk);
        start_i = 1'b0; term_i = 1'b0; mode_ecp_i = 1'b0;
    endtask

    initial begin
        m_clr = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_clr = 1'b0;
        @(negedge clk);
        // reset state
        check(n_selectin_o == 1'b0 && n_autofd_o && n_strobe_o && n_init_o, "R6",
              "reset pins", {n_selectin_o, n_autofd_o, n_strobe_o, n_init_o}, 4'b0111);
        check(done_o == 1'b0, "R10", "reset done", done_o, 0);
        check(mode_o == 2'b00, "R6", "reset mode", mode_o, 0);

        // nibble ok with Select low at latch (R5)
        set_model(1, 1, 0, 0, 0);
        launch(1, 0, 2'b00, 2'b01);
        check(n_selectin_o == 1'b0, "R2", "setup select-in", n_selectin_o, 0);
        while (n_autofd_o) @(negedge clk);
        check(data_o == 8'h00, "R2", "nibble code", data_o, 8'h00);
        check(n_selectin_o && n_strobe_o && n_init_o, "R3", "request pins",
              {n_selectin_o, n_strobe_o, n_init_o}, 3'b111);
        wait_done();
        check(stb_seen, "R4", "strobe pulse seen", stb_seen, 1);
        check(n_selectin_o && n_autofd_o && n_strobe_o && n_init_o, "R6", "1284 idle pins",
              {n_selectin_o, n_autofd_o, n_strobe_o, n_init_o}, 4'b1111);

        // refused start while select-in high (R1)
        exp_q.push_back({2'b10, 2'b01});
        @(negedge clk); start_i = 1'b1; mode_ecp_i = 1'b1;
        @(negedge clk); start_i = 1'b0; mode_ecp_i = 1'b0;
        check(done_o == 1'b1, "R1", "refusal latency", done_o, 1);
        @(negedge clk);
        check(n_selectin_o == 1'b1 && mode_o == 2'b01, "R1", "state kept after refusal",
              {n_selectin_o, mode_o}, 3'b101);

        // termination, full handshake (R7, R8)
        set_model(0, 0, 0, 1, 1);
        launch(0, 0, 2'b00, 2'b00);
        check(mode_o == 2'b00 && !done_o, "R7", "compat during termination", mode_o, 0);
        wait_done();
        check(n_autofd_o && !n_selectin_o, "R8", "end pins ok", {n_autofd_o, n_selectin_o}, 2'b10);

        // ECP accepted (R5, R2)
        set_model(1, 1, 1, 0, 0);
        launch(1, 1, 2'b00, 2'b10);
        while (n_autofd_o) @(negedge clk);
        check(data_o == 8'h30, "R2", "ECP code", data_o, 8'h30);
        wait_done();

        // termination without final acknowledge (R8)
        set_model(0, 0, 0, 1, 0);
        launch(0, 0, 2'b10, 2'b00);
        wait_done();
        check(n_autofd_o == 1'b1, "R8", "auto-feed restored", n_autofd_o, 1);

        // ECP refused by peripheral (R5, R6)
        set_model(1, 1, 0, 0, 0);
        launch(1, 1, 2'b11, 2'b00);
        wait_done();
        check(n_selectin_o == 1'b0 && n_autofd_o, "R6", "compat pins after refusal",
              {n_selectin_o, n_autofd_o}, 2'b01);

        // no answer: timeout, stray requests ignored (R3, R9)
        set_model(0, 0, 0, 0, 0);
        launch(1, 0, 2'b01, 2'b00);
        while (n_autofd_o) @(negedge clk);
        start_i = 1'b1; term_i = 1'b1; mode_ecp_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; term_i = 1'b0; mode_ecp_i = 1'b0;
        @(negedge clk);
        check(data_o == 8'h00 && !n_autofd_o && n_selectin_o, "R9", "busy ignores requests",
              {data_o, n_autofd_o, n_selectin_o}, 10'h001);
        wait_done();
        check(!stb_seen, "R3", "no strobe without answer", stb_seen, 0);

        // no acknowledge rise after strobe (R4)
        set_model(1, 0, 0, 0, 0);
        launch(1, 0, 2'b10, 2'b00);
        wait_done();
        check(stb_seen, "R4", "strobe before latch wait", stb_seen, 1);

        // start and terminate together: start wins (R9)
        set_model(1, 1, 0, 0, 0);
        exp_q.push_back({2'b00, 2'b01});
        @(negedge clk); start_i = 1'b1; term_i = 1'b1;
        @(negedge clk); start_i = 1'b0; term_i = 1'b0;
        check(n_selectin_o == 1'b0 && n_autofd_o, "R9", "start wins", n_selectin_o, 0);
        wait_done();

        // termination with no answer (R7)
        set_model(0, 0, 0, 0, 0);
        launch(0, 0, 2'b10, 2'b00);
        wait_done();
        check(mode_o == 2'b00, "R7", "mode after failed termination", mode_o, 0);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R10", "missing done", exp_q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R10 watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule